// File: doc/BRIEF.md
# Voltage/Frequency Domain Control Register Block

This block gives software a word-addressed register window for managing several voltage/frequency domains. Through it, software can:

- discover how many domains exist and what their identifiers are;
- choose one domain to work on;
- read that domain's level count, and the frequency (kHz) and voltage (µV) of any of its levels;
- request a new performance level for the chosen domain.

The per-domain tables are not stored. They are computed from the domain position by fixed arithmetic.

An accepted level request does two things:

- It updates the domain's requested-level output at once.
- It starts a countdown of the transition latency, converted from nanoseconds to clock cycles.

When the countdown runs out, an acknowledge flag is raised. Software polls for it, and the first read that sees the flag set also clears it. A second accepted request while a countdown is running restarts the countdown, so software sees one acknowledge per burst of requests.

The bus is a single-cycle, APB-like port:

- The read data is combinational, valid while the request is presented.
- State changes take effect at the clock edge that ends the access.
- A global enable input silences the whole window while it is low.

Top module: `dvfs_regif`

## Requirements
- R1: The word index is the byte address shifted right by two, and the address must be word-aligned. Indices 0 to 10 map in this order:
  - 0: status
  - 1: domain count
  - 2: identifier-at-index
  - 3: latency in ns
  - 4: selected domain
  - 5: performance level
  - 6: acknowledge
  - 7: level count
  - 8: level-to-read selector
  - 9: frequency in kHz
  - 10: voltage in µV
- R2: While `en` is low:
  - every read returns 0 and `rsp_err` stays 0;
  - writes change nothing, including the selected domain and the level outputs.
- R3: While enabled:
  - index 0 reads 1;
  - index 1 reads NUM_DOM;
  - index 3 reads LAT_NS.
- R4: A write to index 2 stores a lookup index.
  - Reading index 2 returns the identifier of the domain at that position, which is 2×position.
  - If the position is NUM_DOM or larger, the read returns 0xFFFFFFFF.
- R5: A write to index 4 takes effect only for a valid domain identifier: an even value below 2×NUM_DOM. Any other value leaves the selection unchanged. Index 4 reads back the selection.
- R6: A write to index 5 is accepted only when the value is below the selected domain's level count and differs from its current level.
  - The level count is MAX_LVL − (position mod 2).
  - Domain d drives `level_o[d*LW +: LW]`, and index 5 reads the selected domain's level.
- R7: The acknowledge flag (index 6) becomes 1 exactly LAT_CYC = ceil(LAT_NS/CLK_NS) clock edges after the edge that accepts a level write.
- R8: An accepted level write during a running countdown cancels that countdown and restarts it. Only one acknowledge follows.
- R9: A read of index 6 that returns 1 clears the flag, so the next read returns 0.
- R10: Index 9 returns 500000×(L+1) + 100000×d kHz, and index 10 returns 800000 + 50000×L + 25000×d µV.
  - d is the selected domain's position and L is the level-to-read selector (index 8).
  - Both registers read 0 when L is not below the domain's level count.
  - Index 7 reads the level count.
- R11: While enabled, `rsp_err` is 1 during an access that is unaligned, targets an index above 10, or writes a read-only index (0, 1, 3, 6, 7, 9, 10). Such an access changes no state.
- R12: After reset:
  - the selected domain, lookup index, level-to-read selector, acknowledge flag and all domain levels are 0;
  - no countdown runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable of the register window |
| req_valid | input | 1 | Access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid during a read access |
| rsp_err | output | 1 | Access error for the current access |
| level_o | output | NUM_DOM*LW | Requested level of each domain |

## Verification
The acknowledge path is tried with three patterns:

- A lone accepted request, which pins the exact edge where the flag rises.
- A second request placed mid-countdown, where a flag at the original deadline would reveal a missing cancel, and a second flag later would reveal a double acknowledge.
- Back-to-back reads of the flag, which separate clear-on-read from a flag that sticks.

Level writes that are out of range, or equal to the current level, are mixed with good ones. This tells the acceptance rule apart from a plain store. A random walk over domain selections, level writes and table lookups is compared with a bench model; it exposes wrong domain indexing and table arithmetic. Disabled and erroneous accesses are followed by reads that show state was untouched.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;

  typedef enum logic [3:0] {
    RG_STATUS = 4'd0,
    RG_NDOM   = 4'd1,
    RG_DIDX   = 4'd2,
    RG_LAT    = 4'd3,
    RG_SEL    = 4'd4,
    RG_LVL    = 4'd5,
    RG_ACK    = 4'd6,
    RG_NLVL   = 4'd7,
    RG_LSEL   = 4'd8,
    RG_FREQ   = 4'd9,
    RG_VOLT   = 4'd10
  } reg_e;

  localparam int unsigned RG_LAST = 10;

  // identifier of the domain at a given position
  function automatic logic [31:0] dom_id_of(input int unsigned pos);
    return 32'(2 * pos);
  endfunction

  // number of performance levels of a domain
  function automatic logic [31:0] lvl_count(input int unsigned pos, input int unsigned max_lvl);
    return 32'(max_lvl - (pos % 2));
  endfunction

  function automatic logic [31:0] freq_khz(input int unsigned pos, input int unsigned lvl);
    return 32'(500000 * (lvl + 1) + 100000 * pos);
  endfunction

  function automatic logic [31:0] volt_uv(input int unsigned pos, input int unsigned lvl);
    return 32'(800000 + 50000 * lvl + 25000 * pos);
  endfunction

  function automatic int unsigned lat_cycles(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

endpackage

// File: rtl/dvfs_decode.sv
module dvfs_decode
  import dvfs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          en,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output reg_e          idx,
  output logic          hit_rd,
  output logic          hit_wr,
  output logic          err
);
  localparam int WW = AW - 2;

  logic [WW-1:0] word;
  logic          aligned;
  logic          in_rng;
  logic          writable;
  logic          active;

  assign word    = req_addr[AW-1:2];
  assign aligned = (req_addr[1:0] == 2'b00);
  assign in_rng  = (word <= WW'(RG_LAST));
  assign idx     = in_rng ? reg_e'(word[3:0]) : RG_STATUS;
  assign active  = en && req_valid;

  always_comb begin
    case (idx)
      RG_DIDX, RG_SEL, RG_LVL, RG_LSEL: writable = 1'b1;
      default:                          writable = 1'b0;
    endcase
  end

  assign err    = active && (!aligned || !in_rng || (req_write && !writable));
  assign hit_rd = active && !req_write && !err;
  assign hit_wr = active &&  req_write && !err;
endmodule

// File: rtl/dvfs_ack_timer.sv
module dvfs_ack_timer #(
  parameter int LAT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clr,
  output logic ack,
  output logic busy,
  output logic expire
);
  localparam int CW = $clog2(LAT_CYC + 1);

  logic [CW-1:0] cnt;

  // a restart on the last cycle cancels the pending expiry
  assign expire = (cnt == CW'(1)) && !start;
  assign busy   = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(LAT_CYC);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
    end else if (expire) begin
      ack <= 1'b1;
    end else if (clr) begin
      ack <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_level_bank.sv
module dvfs_level_bank
  import dvfs_pkg::*;
#(
  parameter int NUM_DOM = 3,
  parameter int MAX_LVL = 4,
  parameter int LW      = 2,
  parameter int IW      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_lvl,
  input  logic [IW-1:0]         sel_pos,
  input  logic [31:0]           wdata,
  output logic [NUM_DOM*LW-1:0] levels,
  output logic [LW-1:0]         cur_lvl,
  output logic                  accept
);
  logic [31:0] count;
  logic        lvl_ok;

  always_comb begin
    cur_lvl = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (sel_pos == IW'(d)) cur_lvl = levels[d*LW +: LW];
    end
  end

  assign count  = lvl_count(int'(sel_pos), MAX_LVL);
  assign lvl_ok = (wdata < count) && (wdata[LW-1:0] != cur_lvl);
  assign accept = wr_lvl && lvl_ok;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [LW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (accept && (sel_pos == IW'(d))) begin
        q <= wdata[LW-1:0];
      end
    end
    assign levels[d*LW +: LW] = q;
  end
endmodule

// File: rtl/dvfs_regif.sv
module dvfs_regif
  import dvfs_pkg::*;
#(
  parameter int AW      = 8,
  parameter int NUM_DOM = 3,
  parameter int MAX_LVL = 4,
  parameter int LAT_NS  = 200,
  parameter int CLK_NS  = 10,
  parameter int LW      = (MAX_LVL > 1) ? $clog2(MAX_LVL) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [AW-1:0]         req_addr,
  input  logic [31:0]           req_wdata,
  output logic [31:0]           rsp_rdata,
  output logic                  rsp_err,
  output logic [NUM_DOM*LW-1:0] level_o
);
  localparam int IW      = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;
  localparam int LAT_CYC = lat_cycles(LAT_NS, CLK_NS);

  reg_e        idx;
  logic        hit_rd;
  logic        hit_wr;
  logic [31:0] sel_dom_q;
  logic [31:0] didx_q;
  logic [31:0] lsel_q;
  logic [IW-1:0] sel_pos;
  logic [LW-1:0] cur_lvl;
  logic [31:0] cnt_sel;
  logic        dom_ok;
  logic        accept_evt;
  logic        expire_evt;
  logic        ack_q;
  logic        ack_clr;
  logic        busy;
  logic [31:0] rd_val;

  dvfs_decode #(.AW(AW)) u_dec (
    .en(en), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .idx(idx), .hit_rd(hit_rd), .hit_wr(hit_wr), .err(rsp_err)
  );

  assign sel_pos = sel_dom_q[IW:1];
  assign dom_ok  = !req_wdata[0] && (req_wdata[31:1] < 31'(NUM_DOM));
  assign cnt_sel = lvl_count(int'(sel_pos), MAX_LVL);

  dvfs_level_bank #(.NUM_DOM(NUM_DOM), .MAX_LVL(MAX_LVL), .LW(LW), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_lvl(hit_wr && (idx == RG_LVL)),
    .sel_pos(sel_pos), .wdata(req_wdata),
    .levels(level_o), .cur_lvl(cur_lvl), .accept(accept_evt)
  );

  assign ack_clr = hit_rd && (idx == RG_ACK) && ack_q;

  dvfs_ack_timer #(.LAT_CYC(LAT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept_evt), .clr(ack_clr),
    .ack(ack_q), .busy(busy), .expire(expire_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_dom_q <= '0;
      didx_q    <= '0;
      lsel_q    <= '0;
    end else if (hit_wr) begin
      case (idx)
        RG_DIDX: didx_q <= req_wdata;
        RG_SEL:  if (dom_ok) sel_dom_q <= req_wdata;
        RG_LSEL: lsel_q <= req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    case (idx)
      RG_STATUS: rd_val = 32'd1;
      RG_NDOM:   rd_val = 32'(NUM_DOM);
      RG_DIDX:   rd_val = (didx_q < 32'(NUM_DOM)) ? dom_id_of(didx_q) : 32'hFFFF_FFFF;
      RG_LAT:    rd_val = 32'(LAT_NS);
      RG_SEL:    rd_val = sel_dom_q;
      RG_LVL:    rd_val = 32'(cur_lvl);
      RG_ACK:    rd_val = {31'd0, ack_q};
      RG_NLVL:   rd_val = cnt_sel;
      RG_LSEL:   rd_val = lsel_q;
      RG_FREQ:   rd_val = (lsel_q < cnt_sel) ? freq_khz(int'(sel_pos), lsel_q) : 32'd0;
      RG_VOLT:   rd_val = (lsel_q < cnt_sel) ? volt_uv(int'(sel_pos), lsel_q) : 32'd0;
      default:   rd_val = '0;
    endcase
  end

  assign rsp_rdata = hit_rd ? rd_val : 32'd0;
endmodule

// File: rtl/dvfs_regif_chk.sv
module dvfs_regif_chk #(
  parameter int LAT_CYC = 20,
  parameter int LVW     = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           req_valid,
  input logic [31:0]    rsp_rdata,
  input logic           rsp_err,
  input logic [LVW-1:0] level_o,
  input logic [31:0]    sel_dom,
  input logic           accept_evt,
  input logic           expire_evt,
  input logic           ack_q,
  input logic           ack_clr
);
  localparam int CW = $clog2(LAT_CYC + 1);
  logic [CW-1:0] mcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= '0;
    else if (accept_evt) mcnt <= CW'(LAT_CYC);
    else if (mcnt != '0) mcnt <= mcnt - CW'(1);
  end

  p_dis_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rsp_rdata == 32'd0) && !rsp_err);

  p_dis_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && req_valid) |=> $stable(level_o) && $stable(sel_dom));

  p_accept_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !$stable(level_o));

  p_expire_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |-> (mcnt == CW'(1)) && !accept_evt);

  p_ack_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_q ##1 ack_q |-> (mcnt == '0));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && !expire_evt) |=> !ack_q);

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> $stable(level_o) && $stable(sel_dom));
endmodule

bind dvfs_regif dvfs_regif_chk #(.LAT_CYC(LAT_CYC), .LVW(NUM_DOM*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .level_o(level_o),
  .sel_dom(sel_dom_q), .accept_evt(accept_evt), .expire_evt(expire_evt),
  .ack_q(ack_q), .ack_clr(ack_clr)
);

// File: tb/dvfs_regif_bench.sv
module dvfs_regif_bench;
  localparam int CLK_P   = 10;
  localparam int NDOM    = 3;
  localparam int MAXL    = 4;
  localparam int LATNS   = 200;
  localparam int LW      = 2;
  localparam int LATC    = (LATNS + CLK_P - 1) / CLK_P;

  logic clk = 0;
  logic rst_n = 0;
  logic en = 1;
  logic req_valid = 0;
  logic req_write = 0;
  logic [7:0]  req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [31:0] rsp_rdata;
  logic rsp_err;
  logic [NDOM*LW-1:0] level_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dvfs_regif #(.AW(8), .NUM_DOM(NDOM), .MAX_LVL(MAXL), .LAT_NS(LATNS), .CLK_NS(CLK_P)) u_dvfs_regif (
    .clk(clk), .rst_n(rst_n), .en(en), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .level_o(level_o)
  );

  function automatic int unsigned m_cnt(int unsigned p); return (p % 2 == 1) ? MAXL - 1 : MAXL; endfunction
  function automatic logic [31:0] m_freq(int unsigned p, int unsigned l); return 32'(100000 * p + 500000 + 500000 * l); endfunction
  function automatic logic [31:0] m_volt(int unsigned p, int unsigned l); return 32'(25000 * p + 50000 * l + 800000); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    rd = rsp_rdata; er = rsp_err;
    @(posedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rdr(input int i, output logic [31:0] v);
    logic e;
    bus(1'b0, 8'(i * 4), 32'd0, v, e);
  endtask

  task automatic wrr(input int i, input logic [31:0] d);
    logic [31:0] v; logic e;
    bus(1'b1, 8'(i * 4), d, v, e);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic e;
    int unsigned msel;
    int unsigned mlvl [NDOM];
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12 reset state
    rdr(4, v);  chk("R12 sel", v, 0);
    rdr(8, v);  chk("R12 lsel", v, 0);
    rdr(2, v);  chk("R12 didx", v, 0);
    rdr(6, v);  chk("R12 ack", v, 0);
    rdr(5, v);  chk("R12 lvl", v, 0);
    chk("R12 level_o", 32'(level_o), 0);

    // R1 R3 fixed registers
    rdr(0, v);  chk("R1 R3 status", v, 1);
    rdr(1, v);  chk("R1 R3 ndom", v, NDOM);
    rdr(3, v);  chk("R1 R3 latency", v, LATNS);

    // R4 identifier lookup
    wrr(2, 2);  rdr(2, v); chk("R4 id at 2", v, 4);
    wrr(2, 3);  rdr(2, v); chk("R4 id out of range", v, 32'hFFFF_FFFF);

    // R5 selection validation
    wrr(4, 4);  rdr(4, v); chk("R5 valid sel", v, 4);
    wrr(4, 3);  rdr(4, v); chk("R5 odd id ignored", v, 4);
    wrr(4, 6);  rdr(4, v); chk("R5 large id ignored", v, 4);

    // R6 acceptance on domain 1 (3 levels)
    wrr(4, 2);
    rdr(7, v);  chk("R6 count dom1", v, 3);
    wrr(5, 3);  rdr(5, v); chk("R6 out of range ignored", v, 0);
    wrr(5, 0);  rdr(5, v); chk("R6 same level ignored", v, 0);
    rdr(6, v);  chk("R6 no ack from rejected", v, 0);
    wrr(5, 2);
    // R7 window: read just before and at the expiry
    repeat (LATC - 1) @(posedge clk);
    rdr(6, v);  chk("R7 ack not yet", v, 0);
    rdr(6, v);  chk("R7 ack raised", v, 1);
    rdr(6, v);  chk("R9 ack cleared", v, 0);
    rdr(5, v);  chk("R6 level read", v, 2);
    chk("R6 level_o dom1", 32'(level_o[LW +: LW]), 2);

    // R8 restart
    wrr(5, 1);
    repeat (8) @(posedge clk);
    wrr(5, 2);
    repeat (LATC - 1) @(posedge clk);
    rdr(6, v);  chk("R8 first countdown cancelled", v, 0);
    rdr(6, v);  chk("R8 ack after restart", v, 1);
    repeat (2 * LATC) @(posedge clk);
    rdr(6, v);  chk("R8 single ack", v, 0);

    // R10 table lookups
    wrr(8, 1);
    rdr(9, v);  chk("R10 freq", v, m_freq(1, 1));
    rdr(10, v); chk("R10 volt", v, m_volt(1, 1));
    wrr(8, 3);
    rdr(9, v);  chk("R10 freq beyond", v, 0);
    rdr(10, v); chk("R10 volt beyond", v, 0);

    // R11 errors
    bus(1'b0, 8'd44, 0, v, e); chk("R11 index 11 err", 32'(e), 1);
    bus(1'b0, 8'd2, 0, v, e);  chk("R11 unaligned err", 32'(e), 1);
    bus(1'b1, 8'd0, 5, v, e);  chk("R11 ro write err", 32'(e), 1);
    bus(1'b1, 8'd17, 0, v, e); chk("R11 unaligned write err", 32'(e), 1);
    rdr(4, v);  chk("R11 sel unchanged", v, 2);
    bus(1'b0, 8'd16, 0, v, e); chk("R11 good access no err", 32'(e), 0);

    // R2 disabled window
    en = 0;
    bus(1'b0, 8'd0, 0, v, e);  chk("R2 status reads 0", v, 0);
    chk("R2 no err", 32'(e), 0);
    bus(1'b1, 8'd16, 0, v, e);
    bus(1'b1, 8'd20, 0, v, e);
    chk("R2 level_o held", 32'(level_o[LW +: LW]), 2);
    en = 1;
    rdr(4, v);  chk("R2 sel unchanged", v, 2);

    // random walk against a model (R5 R6 R10)
    msel = 1;
    mlvl[0] = 0; mlvl[1] = 2; mlvl[2] = 0;
    for (int it = 0; it < 60; it++) begin
      int unsigned d, l, r;
      d = $urandom_range(0, 7);
      wrr(4, d);
      if (d % 2 == 0 && d / 2 < NDOM) msel = d / 2;
      l = $urandom_range(0, MAXL);
      wrr(5, l);
      if (l < m_cnt(msel) && l != mlvl[msel]) mlvl[msel] = l;
      rdr(5, v); chk("R6 random level", v, mlvl[msel]);
      chk("R6 random level_o", 32'(level_o[msel*LW +: LW]), mlvl[msel]);
      r = $urandom_range(0, MAXL);
      wrr(8, r);
      rdr(9, v);  chk("R10 random freq", v, (r < m_cnt(msel)) ? m_freq(msel, r) : 0);
      rdr(10, v); chk("R10 random volt", v, (r < m_cnt(msel)) ? m_volt(msel, r) : 0);
      rdr(4, v);  chk("R5 random sel", v, 2 * msel);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule